// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a target device holds stuck, for example with its data line pulled low partway through a byte. It drives nothing on the bus directly. It produces two open-drain pull-low enables, one for the clock line and one for the data line, which the pad logic uses to force the lines low. With an enable clear, the pad releases its line and the external pull-up takes it high.

A one-cycle trigger starts the sequence. The sequencer first clocks the bus a fixed number of times (nine by default) with the data line released. This lets a target that is partway through a transfer finish shifting its bits and let go of the data line. The sequencer then builds a stop condition by hand, in three steps:

- both lines are held low;
- the clock is released while data stays low;
- both lines are released, so data rises while the clock is high.

Every phase is held for the same dwell time. That time is a cycle count derived at elaboration from the system clock frequency and the wanted dwell in nanoseconds. A `busy` flag covers the whole run, and a one-cycle `done` pulse marks its end. The block does not check whether the bus actually recovered, and it takes no part in arbitration.

Top module: `busrec_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the block returns to idle. In the following cycle `scl_pull`, `sda_pull`, `busy` and `done` are all 0, even if a sequence was running or `start` is high.
- R2: `start` is sampled only while the block is idle. A `start` seen while `busy` is high neither restarts nor alters the running sequence. With no `start`, an idle block stays idle with both lines released.
- R3: The run begins with NUM_PULSES clock pulses. Each pulse is one phase with both enables at 0, followed by one phase with `scl_pull`=1 and `sda_pull`=0. `sda_pull` stays 0 during all pulse phases.
- R4: The phase after the last pulse has `scl_pull`=1 and `sda_pull`=1.
- R5: The next phase has `scl_pull`=0 and `sda_pull`=1.
- R6: The last phase has both enables at 0, so data is released while the clock is already released (a stop condition). `sda_pull` never falls while `scl_pull` is 1.
- R7: Every phase lasts exactly DWELL_CYC cycles. DWELL_CYC = ceil(CLK_HZ × DWELL_NS / 10^9), with a minimum of 1. The first phase begins in the cycle after the edge that accepts `start`.
- R8: `busy` is 1 from the cycle after acceptance through the last cycle of the final phase. In the next cycle `busy` is 0 and `done` is 1 for exactly one cycle. A `start` in that cycle is accepted.
- R9: Polarity: an enable at 1 means that line is forced low; an enable at 0 means the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Trigger for a recovery run, sampled only when idle |
| scl_pull | output | 1 | Pull-low enable for the clock line (1 = force low) |
| sda_pull | output | 1 | Pull-low enable for the data line (1 = force low) |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse after the final phase ends |

## Verification
The block is driven four ways.

1. **Clean single trigger.** It fixes the exact cycle at which each phase boundary falls.
2. **Triggers sprayed randomly while busy.** These runs separate a sequencer that ignores `start` mid-run from one that restarts or skips phases.
3. **Back-to-back trigger in the `done` cycle.** It shows that the idle cycle accepts a new run without a lost or extra phase.
4. **Reset raised mid-run with `start` held high.** It shows that reset wins over the trigger and leaves both lines released.

Each sampled cycle is compared against a phase index computed from the elapsed cycle count. This catches both wrong line levels and off-by-one phase lengths.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CLK_HI   = 3'd1,
    PH_CLK_LO   = 3'd2,
    PH_HOLD_LOW = 3'd3,
    PH_CLK_UP   = 3'd4,
    PH_RELEASE  = 3'd5
  } phase_t;

  // Cycles per phase: ceiling of hz*ns/1e9, never below one.
  function automatic int unsigned dwell_cycles(int unsigned hz, int unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(hz) * longint'(ns);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/busrec_dwell_timer.sv
module busrec_dwell_timer #(
  parameter int unsigned DWELL = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int unsigned W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [W-1:0] LAST = W'(DWELL - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/busrec_pulse_ctr.sv
module busrec_pulse_ctr #(
  parameter int unsigned NUM = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned W = (NUM > 1) ? $clog2(NUM) : 1;
  localparam logic [W-1:0] FINAL = W'(NUM - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == FINAL);
endmodule

// File: rtl/busrec_phase_fsm.sv
module busrec_phase_fsm
  import busrec_pkg::*;
#(
  parameter int unsigned DWELL      = 1,
  parameter int unsigned NUM_PULSES = 9
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   done_q
);
  logic run, step, last_pulse, clr_pulses, inc_pulse;

  assign run = (phase_q != PH_IDLE);

  busrec_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .clear  (step),
    .expire (step)
  );

  busrec_pulse_ctr #(.NUM(NUM_PULSES)) u_pulses (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_pulses),
    .inc  (inc_pulse),
    .last (last_pulse)
  );

  always_comb begin
    phase_d    = phase_q;
    clr_pulses = 1'b0;
    inc_pulse  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d    = PH_CLK_HI;
          clr_pulses = 1'b1;
        end
      end
      PH_CLK_HI:   if (step) phase_d = PH_CLK_LO;
      PH_CLK_LO: begin
        if (step) begin
          inc_pulse = 1'b1;
          phase_d   = last_pulse ? PH_HOLD_LOW : PH_CLK_HI;
        end
      end
      PH_HOLD_LOW: if (step) phase_d = PH_CLK_UP;
      PH_CLK_UP:   if (step) phase_d = PH_RELEASE;
      PH_RELEASE:  if (step) phase_d = PH_IDLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_RELEASE) && step;
    end
  end
endmodule

// File: rtl/busrec_line_drive.sv
module busrec_line_drive
  import busrec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_d,
  output logic   scl_pull,
  output logic   sda_pull
);
  logic scl_n, sda_n;

  always_comb begin
    scl_n = 1'b0;
    sda_n = 1'b0;
    case (phase_d)
      PH_CLK_LO:   scl_n = 1'b1;
      PH_HOLD_LOW: begin scl_n = 1'b1; sda_n = 1'b1; end
      PH_CLK_UP:   sda_n = 1'b1;
      default:     ;
    endcase
  end

  // Registered so the pad enables never glitch.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      scl_pull <= scl_n;
      sda_pull <= sda_n;
    end
  end
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned DWELL_NS   = 5000,
  parameter int unsigned NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done
);
  localparam int unsigned DWELL_CYC = dwell_cycles(CLK_HZ, DWELL_NS);

  phase_t phase_q, phase_d;

  busrec_phase_fsm #(.DWELL(DWELL_CYC), .NUM_PULSES(NUM_PULSES)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .phase_q (phase_q),
    .phase_d (phase_d),
    .done_q  (done)
  );

  busrec_line_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .phase_d  (phase_d),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
  );

  assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/busrec_seq_chk.sv
module busrec_seq_chk #(
  parameter int unsigned DWELL = 1
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done
);
  logic [1:0]  prev_o;
  logic        prev_busy;
  logic [31:0] len_q;
  logic        edge_o, begin_run;

  assign edge_o    = ({scl_pull, sda_pull} != prev_o);
  assign begin_run = busy && !prev_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_o    <= 2'b00;
      prev_busy <= 1'b0;
      len_q     <= 32'd0;
    end else begin
      prev_o    <= {scl_pull, sda_pull};
      prev_busy <= busy;
      if (edge_o || begin_run) len_q <= 32'd1;
      else if (len_q != 32'hFFFF_FFFF) len_q <= len_q + 32'd1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!scl_pull && !sda_pull && !busy && !done));

  a_r2_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  a_r3_clock_low_data_free: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> !sda_pull);

  a_r6_stop_order: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> !scl_pull);

  a_r7_phase_len: assert property (@(posedge clk) disable iff (rst)
    (busy && prev_busy && edge_o) |-> (len_q == DWELL));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind busrec_seq busrec_seq_chk #(.DWELL(DWELL_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done)
);

// File: tb/busrec_seq_tb.sv
module busrec_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 9;
  localparam int DW  = 5;           // 100 MHz, 50 ns -> 5 cycles
  localparam int NPH = 2 * NP + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scl_pull, sda_pull, busy, done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  busrec_seq #(.CLK_HZ(100_000_000), .DWELL_NS(50), .NUM_PULSES(NP)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done)
  );

  // Expected {scl_pull, sda_pull} for a phase index.
  function automatic logic [1:0] exp_lines(int ph);
    if (ph < 2 * NP)          return (ph % 2 == 1) ? 2'b10 : 2'b00;
    else if (ph == 2 * NP)    return 2'b11;
    else if (ph == 2 * NP + 1) return 2'b01;
    else                      return 2'b00;
  endfunction

  function automatic string phase_req(int ph);
    if (ph < 2 * NP)           return "R3";
    else if (ph == 2 * NP)     return "R4";
    else if (ph == 2 * NP + 1) return "R5";
    else                       return "R6";
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] got;
    got = {scl_pull, sda_pull, busy, done};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got scl/sda/busy/done=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // start was set before the accepting edge; runs through the done cycle.
  task automatic run_body(int pct, bit restart);
    for (int c = 0; c < NPH * DW; c++) begin
      @(negedge clk);
      if (c % DW == 0 || c % DW == DW - 1)
        chk("R7", {exp_lines(c / DW), 2'b10});
      else
        chk(phase_req(c / DW), {exp_lines(c / DW), 2'b10});
      start = ($urandom_range(0, 99) < pct);
    end
    @(negedge clk);
    chk("R8", 4'b0001);
    start = restart;
    if (!restart) begin
      @(negedge clk);
      chk("R8", 4'b0000);
    end
  endtask

  task automatic idle_gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2", 4'b0000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 4'b0000);
    chk("R9", 4'b0000);
    rst = 1'b0;
    idle_gap(4);

    // Clean single run.
    start = 1'b1;
    run_body(0, 1'b0);

    // Runs with triggers sprayed while busy.
    for (int k = 0; k < 5; k++) begin
      idle_gap($urandom_range(0, 7));
      start = 1'b1;
      run_body(30 + 10 * k, 1'b0);
    end

    // Back-to-back: new trigger in the done cycle.
    start = 1'b1;
    run_body(20, 1'b1);
    run_body(0, 1'b0);

    // Reset mid-run with start held.
    start = 1'b1;
    repeat (38) @(negedge clk);
    rst = 1'b1;
    start = 1'b1;
    @(negedge clk);
    chk("R1", 4'b0000);
    @(negedge clk);
    chk("R1", 4'b0000);
    rst = 1'b0;
    start = 1'b0;
    idle_gap(6);

    // Recovery after reset.
    start = 1'b1;
    run_body(50, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule